// File: doc/BRIEF.md
# Store-Wait Load Dependence Predictor

This block remembers which loads have earlier been caught reading memory ahead of an older store to the same address. It holds one flag per table slot, and the slot is picked from the load's program counter. When the front end fetches a load, it presents the PC. One cycle later the block returns a wait flag that travels with the instruction. The issue logic keeps a flagged load back until every older store has issued. That logic sits outside this block.

The commit stage trains the table. When a load traps at commit because of an ordering violation, it presents that load's PC, and the slot for that PC is set. A slot is never cleared one at a time. Instead, an internal free-running cycle counter wipes the entire table in one cycle at a fixed interval. This lets predictions that have gone stale fade out without any extra per-slot storage.

Top module: `swp_store_wait_pred`

## Requirements
- R1: After a synchronous active-low reset, `lkp_wait` is 0. Every slot reads as 0 until it is trained.
- R2: `lkp_wait` is registered. It shows the slot value one cycle after a cycle with `lkp_valid` high, and it is 0 one cycle after a cycle with `lkp_valid` low.
- R3: The slot index is PC bits [11:2] (1024 slots, 4-byte-aligned instructions). PCs that differ only in bits [1:0] or in bits above 11 share a slot.
- R4: A cycle with `trn_valid` high sets the slot of `trn_pc`. A lookup of that slot in any later cycle, before the next wipe, returns 1.
- R5: A lookup and a train of the same slot in the same cycle return the value the slot held before that cycle.
- R6: The whole table is wiped on the clock edge at which the internal cycle counter reaches 65535. The counter is 0 during reset and steps once per edge after reset, so this happens on the 65536th edge after reset is released and every 65536 edges after that.
- R7: When a train and a wipe fall on the same edge, the wipe wins and the trained slot stays 0.
- R8: A train changes only its own slot. Other slots keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lkp_valid | input | 1 | Fetch-time lookup request |
| lkp_pc | input | 32 | PC of the fetched load |
| trn_valid | input | 1 | Commit-time trap of a load |
| trn_pc | input | 32 | PC of the trapped load |
| lkp_wait | output | 1 | Wait flag for the load looked up in the previous cycle |

## Verification
Two events can land on the same edge: a train and the periodic wipe. A lookup and a train of one slot can also coincide. The bench drives random traffic until its own cycle counter shows that the next edge is the wipe edge. On that edge it trains a fresh slot while it looks up an already trained one. The lookup must still return the old 1. Lookups of both slots in the following cycles must return 0, which shows that the wipe won over the train. A same-slot lookup and train is also driven well away from the wipe and must return the pre-train value.

// File: rtl/swp_pkg.sv
// Package: shared constants and the table operation encoding for the
// store-wait predictor. Assumes 32-bit PCs and 4-byte-aligned instructions.
package swp_pkg;
    localparam int unsigned SWP_PC_W        = 32;
    localparam int unsigned SWP_IDX_W       = 10;
    localparam int unsigned SWP_IDX_LSB     = 2;
    localparam int unsigned SWP_DECAY_LOG2  = 16;

    // Operation applied to the table on one edge; the wipe outranks a set.
    typedef enum logic [1:0] {
        TBL_HOLD = 2'd0,
        TBL_SET  = 2'd1,
        TBL_WIPE = 2'd2
    } tbl_op_e;
endpackage

// File: rtl/swp_decay_timer.sv
// Decay timer: a free-running counter that pulses for one cycle whenever it
// holds its all-ones value. Assumes the counter width is the log2 of the
// wipe interval; it is zero during reset.
module swp_decay_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic wipe_now
);
    logic [CNT_W-1:0] cnt_q;

    // Step the counter once per cycle, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Flag the last count of each interval.
    always_comb wipe_now = &cnt_q;
endmodule

// File: rtl/swp_bit_table.sv
// Bit table: one flag per slot with a registered read port and a single
// update port. Assumes the caller resolves priority into one operation per
// cycle. A read of a slot being updated returns the pre-update value.
module swp_bit_table
    import swp_pkg::*;
#(
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit,
    input  tbl_op_e          op,
    input  logic [IDX_W-1:0] wr_idx
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] flags_q;
    logic             rd_q;

    // Apply this cycle's table operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            unique case (op)
                TBL_WIPE: flags_q         <= '0;
                TBL_SET:  flags_q[wr_idx] <= 1'b1;
                default:  flags_q         <= flags_q;
            endcase
        end
    end

    // Capture the addressed flag, or zero when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_en & flags_q[rd_idx];
    end

    always_comb rd_bit = rd_q;
endmodule

// File: rtl/swp_store_wait_pred.sv
// Store-wait predictor top: slices the slot index out of the fetch and
// commit PCs, resolves wipe-over-set priority and drives the bit table.
// Assumes the index field lies strictly inside the PC (0 < IDX_LSB and
// IDX_LSB + IDX_W < PC_W).
module swp_store_wait_pred
    import swp_pkg::*;
#(
    parameter int unsigned PC_W       = SWP_PC_W,
    parameter int unsigned IDX_W      = SWP_IDX_W,
    parameter int unsigned IDX_LSB    = SWP_IDX_LSB,
    parameter int unsigned DECAY_LOG2 = SWP_DECAY_LOG2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lkp_valid,
    input  logic [PC_W-1:0] lkp_pc,
    input  logic            trn_valid,
    input  logic [PC_W-1:0] trn_pc,
    output logic            lkp_wait
);
    localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

    logic [IDX_W-1:0] lkp_idx;
    logic [IDX_W-1:0] trn_idx;
    logic             clr_pulse;
    tbl_op_e          tbl_op;
    logic             unused_pc_bits;

    // Slot index of each PC; the bits outside the field are ignored.
    always_comb begin
        lkp_idx = lkp_pc[IDX_MSB:IDX_LSB];
        trn_idx = trn_pc[IDX_MSB:IDX_LSB];
    end

    assign unused_pc_bits = ^{lkp_pc[IDX_LSB-1:0], lkp_pc[PC_W-1:IDX_MSB+1],
                              trn_pc[IDX_LSB-1:0], trn_pc[PC_W-1:IDX_MSB+1]};

    swp_decay_timer #(
        .CNT_W (DECAY_LOG2)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe_now (clr_pulse)
    );

    // Pick one table operation: the wipe outranks a training set.
    always_comb begin
        if (clr_pulse)      tbl_op = TBL_WIPE;
        else if (trn_valid) tbl_op = TBL_SET;
        else                tbl_op = TBL_HOLD;
    end

    swp_bit_table #(
        .IDX_W (IDX_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (lkp_valid),
        .rd_idx (lkp_idx),
        .rd_bit (lkp_wait),
        .op     (tbl_op),
        .wr_idx (trn_idx)
    );
endmodule

// File: rtl/swp_store_wait_pred_chk.sv
// Checker for the store-wait predictor, bound to the top. It watches the
// ports and the internal wipe pulse and keeps its own interval counter.
module swp_store_wait_pred_chk #(
    parameter int unsigned PC_W       = 32,
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned IDX_LSB    = 2,
    parameter int unsigned DECAY_LOG2 = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lkp_valid,
    input logic [PC_W-1:0] lkp_pc,
    input logic            trn_valid,
    input logic [PC_W-1:0] trn_pc,
    input logic            lkp_wait,
    input logic            clr_pulse
);
    logic [IDX_W-1:0]      l_idx;
    logic [IDX_W-1:0]      t_idx;
    logic [DECAY_LOG2-1:0] gap_q;

    always_comb begin
        l_idx = lkp_pc[IDX_LSB +: IDX_W];
        t_idx = trn_pc[IDX_LSB +: IDX_W];
    end

    // Independent count of edges since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_q + 1'b1;
    end

    AST_RESET_CLEARS_WAIT: assert property (@(posedge clk) !rst_n |=> !lkp_wait); // R1
    AST_IDLE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> !lkp_wait); // R2
    AST_TRAIN_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_valid && !clr_pulse) |=> ((lkp_valid && l_idx == $past(t_idx)) |=> lkp_wait)); // R4
    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> ((lkp_valid && !trn_valid) |=> !lkp_wait)); // R6
    AST_WIPE_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse == (&gap_q)); // R6
    AST_WIPE_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && trn_valid) |=> ((lkp_valid && l_idx == $past(t_idx) && !clr_pulse) |=> !lkp_wait)); // R7
endmodule

bind swp_store_wait_pred swp_store_wait_pred_chk #(
    .PC_W       (PC_W),
    .IDX_W      (IDX_W),
    .IDX_LSB    (IDX_LSB),
    .DECAY_LOG2 (DECAY_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .lkp_pc    (lkp_pc),
    .trn_valid (trn_valid),
    .trn_pc    (trn_pc),
    .lkp_wait  (lkp_wait),
    .clr_pulse (clr_pulse)
);

// File: tb/swp_store_wait_pred_tb.sv
`timescale 1ns/1ps
module swp_store_wait_pred_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [31:0] lkp_pc = '0;
    logic        trn_valid = 1'b0;
    logic [31:0] trn_pc = '0;
    logic        lkp_wait;

    int compared = 0;
    int mismatched = 0;
    bit model [1024];
    int mcount = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    swp_store_wait_pred u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lkp_valid (lkp_valid),
        .lkp_pc    (lkp_pc),
        .trn_valid (trn_valid),
        .trn_pc    (trn_pc),
        .lkp_wait  (lkp_wait)
    );

    function automatic int slot(input logic [31:0] pc);
        return int'(pc[11:2]);
    endfunction

    task automatic compare(input string req, input logic got, input logic exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: lkp_wait=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(input string req, input bit lv, input logic [31:0] lpc,
                        input bit tv, input logic [31:0] tpc);
        bit exp;
        bit wipe;
        lkp_valid = lv; lkp_pc = lpc; trn_valid = tv; trn_pc = tpc;
        exp  = lv ? model[slot(lpc)] : 1'b0;
        wipe = (mcount == 65535);
        @(posedge clk);
        if (wipe)    foreach (model[i]) model[i] = 1'b0;
        else if (tv) model[slot(tpc)] = 1'b1;
        mcount = (mcount + 1) % 65536;
        @(negedge clk);
        compare(req, lkp_wait, exp);
    endtask

    localparam logic [31:0] PC_A = 32'h1000_0040;
    localparam logic [31:0] PC_B = 32'h2000_0800;
    localparam logic [31:0] PC_C = 32'h0000_0ffc;

    initial begin
        repeat (3) @(negedge clk);
        compare("R1", lkp_wait, 1'b0);
        rst_n = 1'b1;
        mcount = 0;
        // R1: untrained slots read zero
        step("R1", 1, PC_A, 0, 0);
        step("R1", 1, PC_C, 0, 0);
        // R4: train then look up
        step("R4", 0, 0, 1, PC_A);
        step("R4", 1, PC_A, 0, 0);
        // R3: aliasing through low and high PC bits
        step("R3", 1, PC_A | 32'h3, 0, 0);
        step("R3", 1, PC_A ^ 32'hfff0_1000, 0, 0);
        // R8: neighbouring slot untouched
        step("R8", 1, PC_A + 32'd4, 0, 0);
        step("R8", 1, PC_A - 32'd4, 0, 0);
        // R5: same-cycle lookup and train returns the old value
        step("R5", 1, PC_B, 1, PC_B);
        step("R5", 1, PC_B, 0, 0);
        // R2: no lookup gives zero even for a set slot
        step("R2", 0, PC_A, 0, 0);
        // R2: random mixed traffic until the edge before the wipe
        while (mcount != 65535) begin
            bit lv = ($urandom % 2) == 1;
            bit tv = ($urandom % 8) == 0;
            logic [31:0] lpc = $urandom;
            logic [31:0] tpc = $urandom;
            if (tpc[11:2] == PC_C[11:2]) tpc[2] = ~tpc[2];
            step("R2", lv, lpc, tv, tpc);
        end
        // R7: train on the wipe edge; the read still sees the old A
        step("R7", 1, PC_A, 1, PC_C);
        step("R6", 1, PC_A, 0, 0);
        step("R7", 1, PC_C, 0, 0);
        step("R6", 1, PC_B, 0, 0);
        // R4: training works again after the wipe
        step("R4", 0, 0, 1, PC_C);
        step("R4", 1, PC_C, 0, 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule